// File: doc/BRIEF.md
# Flash Address Range Guard

This block sits in front of the command engine of a serial flash controller. When software triggers an indirect read, an indirect write or a status-polling command, the guard compares the programmed start address, and for indirect commands also the last byte of the transfer, with the flash capacity. It then gives the engine a one-cycle decision: go or abort.

A legal access pulses `go` and raises `busy`. `busy` stays high until the engine reports completion. A faulting access pulses `abort` instead, leaves `busy` low and sets a sticky error flag. That flag drives an interrupt request when the interrupt is enabled. Triggers in memory-mapped mode, and triggers that arrive while an access is running, are dropped. Range checking for memory-mapped bus accesses is handled by other logic.

Top module: `flash_range_guard`

## Requirements
- R1: After a synchronous reset, `go`, `abort`, `busy`, `err_flag` and `irq` are all 0.
- R2: A trigger in an indirect mode (`mode` 00 = write, 01 = read) whose start address is greater than or equal to the flash size gives an `abort` pulse on the next cycle, with no `go` pulse, and sets `err_flag`.
- R3: In an indirect mode, `len` holds the byte count minus one. The access faults when `addr + len + 1` is greater than the flash size. An access whose last byte is exactly the last flash byte is legal.
- R4: In status-polling mode (`mode` 10), only the start address is checked, and `len` has no effect on the decision.
- R5: A legal trigger gives a single-cycle `go` pulse on the cycle after the trigger. `busy` rises on the same cycle, stays high, and falls on the cycle after `op_done`. A faulting access leaves `busy` low.
- R6: While `busy` is high, `trig` is ignored: no `go`, no `abort`, and no change to `err_flag`.
- R7: A trigger in memory-mapped mode (`mode` 11) is ignored: no `go`, no `abort` and no error.
- R8: `err_flag` stays set until an `err_clr` strobe, and it falls on the cycle after that strobe. If a new fault arrives in the same cycle as the clear, the flag stays set.
- R9: `irq` equals `err_flag` AND `err_ie`, with the enable sampled one cycle earlier. `irq` is never high while `err_flag` is low.
- R10: The flash size is 2^(`fsize`+1) bytes, limited to 2^ADDR_W. The end-address sum is formed with spare bits, so the largest address plus the largest length faults and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Command start strobe |
| mode | input | 2 | Functional mode: 00 indirect write, 01 indirect read, 10 status polling, 11 memory-mapped |
| addr | input | ADDR_W | Start byte address |
| len | input | LEN_W | Byte count minus one |
| fsize | input | 5 | Size exponent; flash size is 2^(fsize+1) bytes |
| err_ie | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Error flag clear strobe |
| op_done | input | 1 | Completion report from the command engine |
| go | output | 1 | Start pulse for a legal access |
| abort | output | 1 | Refusal pulse for a faulting access |
| busy | output | 1 | Access in progress |
| err_flag | output | 1 | Sticky transfer-error flag |
| irq | output | 1 | Error interrupt request |

## Verification
A wrong limit or a wrong end-address sum shows up one cycle after the trigger: `go` and `abort` swap, and `busy` and `err_flag` follow with them. The bench therefore aims addresses and lengths at the exact size boundary, at one byte past it, and at the largest possible values. A lost acceptance gate shows up only when a trigger lands while an access is running or while in memory-mapped mode, so both cases are driven on purpose. A bad sticky bit or a bad interrupt gate shows up on the cycles after a fault and after the clear strobe.

// File: rtl/frg_pkg.sv
package frg_pkg;
  typedef enum logic [1:0] {
    M_IND_WR = 2'b00,
    M_IND_RD = 2'b01,
    M_POLL   = 2'b10,
    M_MMAP   = 2'b11
  } frg_mode_e;

  function automatic logic mode_is_indirect(input logic [1:0] m);
    return (m == M_IND_WR) || (m == M_IND_RD);
  endfunction
endpackage

// File: rtl/frg_range_calc.sv
module frg_range_calc #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int FS_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [FS_W-1:0]   fsize,
  input  logic [1:0]        mode,
  output logic              fault
);
  localparam int WIDE  = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;
  localparam int SUM_W = WIDE + 2;
  localparam logic [FS_W:0] AW_CAP = (FS_W+1)'(ADDR_W);

  logic [FS_W:0]    size_exp;
  logic [SUM_W-1:0] limit;
  logic [SUM_W-1:0] start_ext;
  logic [SUM_W-1:0] end_ext;
  logic             past_start;
  logic             past_end;

  always_comb begin
    size_exp = {1'b0, fsize} + 1'b1;
    if (size_exp >= AW_CAP) limit = SUM_W'(1) << AW_CAP;
    else                    limit = SUM_W'(1) << size_exp;
    start_ext  = SUM_W'(addr);
    end_ext    = start_ext + SUM_W'(len) + SUM_W'(1);
    past_start = (start_ext >= limit);
    past_end   = (end_ext > limit);
    fault      = past_start | (frg_pkg::mode_is_indirect(mode) & past_end);
  end
endmodule

// File: rtl/frg_err_status.sv
module frg_err_status (
  input  logic clk,
  input  logic rst,
  input  logic set_err,
  input  logic err_clr,
  input  logic err_ie,
  output logic err_flag,
  output logic irq
);
  logic flag_nxt;

  always_comb flag_nxt = set_err | (err_flag & ~err_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      err_flag <= flag_nxt;
      irq      <= flag_nxt & err_ie;
    end
  end

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> err_flag);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(err_flag) |-> $past(err_clr));
endmodule

// File: rtl/frg_busy_ctrl.sv
module frg_busy_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic fault,
  input  logic op_done,
  output logic go,
  output logic abort,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      go    <= 1'b0;
      abort <= 1'b0;
      busy  <= 1'b0;
    end else begin
      go    <= accept & ~fault;
      abort <= accept & fault;
      if (accept & ~fault) busy <= 1'b1;
      else if (op_done)    busy <= 1'b0;
    end
  end

  assert_go_abort_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(go && abort));
  assert_busy_rise_go_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> go);
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> !abort && !go);
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int FS_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [FS_W-1:0]   fsize,
  input  logic              err_ie,
  input  logic              err_clr,
  input  logic              op_done,
  output logic              go,
  output logic              abort,
  output logic              busy,
  output logic              err_flag,
  output logic              irq
);
  logic fault_c;
  logic accept;

  frg_range_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FS_W(FS_W)) u_calc (
    .addr(addr), .len(len), .fsize(fsize), .mode(mode), .fault(fault_c));

  always_comb accept = trig & ~busy & (mode != frg_pkg::M_MMAP);

  frg_busy_ctrl u_busy (
    .clk(clk), .rst(rst), .accept(accept), .fault(fault_c),
    .op_done(op_done), .go(go), .abort(abort), .busy(busy));

  frg_err_status u_err (
    .clk(clk), .rst(rst), .set_err(accept & fault_c), .err_clr(err_clr),
    .err_ie(err_ie), .err_flag(err_flag), .irq(irq));

  assert_mmap_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (trig && mode == frg_pkg::M_MMAP) |=> !go && !abort);
  assert_err_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> abort);
endmodule

// File: tb/flash_range_guard_tb.sv
module flash_range_guard_tb_top;
  localparam int AW = 32;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst, trig, err_ie, err_clr, op_done;
  logic [1:0] mode;
  logic [AW-1:0] addr;
  logic [LW-1:0] len;
  logic [4:0] fsize;
  logic go, abort, busy, err_flag, irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_range_guard #(.ADDR_W(AW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst), .trig(trig), .mode(mode), .addr(addr), .len(len),
    .fsize(fsize), .err_ie(err_ie), .err_clr(err_clr), .op_done(op_done),
    .go(go), .abort(abort), .busy(busy), .err_flag(err_flag), .irq(irq));

  function automatic logic exp_fault(input logic [1:0] m, input logic [AW-1:0] a,
                                     input logic [LW-1:0] l, input logic [4:0] fs);
    longint unsigned sz, e;
    sz = (int'(fs) + 1 >= AW) ? (64'd1 << AW) : (64'd1 << (fs + 1));
    e  = longint'(a) + longint'(l) + 1;
    if (longint'(a) >= sz) return 1'b1;
    if (m[1] == 1'b0 && e > sz) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input logic act, input logic ex, input string what);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, ex);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_out();
    op_done = 1'b1; err_clr = 1'b1;
    step();
    op_done = 1'b0; err_clr = 1'b0;
  endtask

  task automatic run(input logic [1:0] m, input logic [AW-1:0] a,
                     input logic [LW-1:0] l, input logic [4:0] fs,
                     input logic ie, input string tag);
    logic f, ign;
    ign = (m == 2'b11);
    f = exp_fault(m, a, l, fs) & ~ign;
    mode = m; addr = a; len = l; fsize = fs; err_ie = ie; trig = 1'b1;
    step();
    trig = 1'b0;
    chk(go, ~f & ~ign, {tag, " go"});
    chk(abort, f, {tag, " abort"});
    chk(busy, ~f & ~ign, {tag, " busy"});
    chk(err_flag, f, {tag, " err_flag"});
    chk(irq, f & ie, {tag, " R9 irq"});
    idle_out();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; trig = 0; err_ie = 0; err_clr = 0; op_done = 0;
    mode = 0; addr = 0; len = 0; fsize = 0;
    step(); step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(go, 0, "R1 go"); chk(abort, 0, "R1 abort"); chk(busy, 0, "R1 busy");
    chk(err_flag, 0, "R1 err_flag"); chk(irq, 0, "R1 irq");

    // R2 start address at size (fsize 9 -> 1024 bytes)
    run(2'b01, 32'd1024, 32'd0, 5'd9, 1'b1, "R2 addr==size");
    run(2'b00, 32'd1023, 32'd0, 5'd9, 1'b1, "R2 last byte");
    // R3 exact end legal, one past faults
    run(2'b01, 32'd1000, 32'd23, 5'd9, 1'b0, "R3 exact end");
    run(2'b00, 32'd1000, 32'd24, 5'd9, 1'b1, "R3 one past");
    // R4 polling ignores length
    run(2'b10, 32'd1000, 32'hFFFF_FFFF, 5'd9, 1'b1, "R4 poll long len");
    run(2'b10, 32'd1024, 32'd0, 5'd9, 1'b1, "R4 poll addr bad");
    // R7 memory-mapped ignored
    run(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1, "R7 mmap");
    // R10 full space, no wrap
    run(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 1'b1, "R10 no wrap");
    run(2'b01, 32'h0, 32'hFFFF_FFFF, 5'd31, 1'b1, "R10 whole space");
    run(2'b00, 32'h0, 32'd1, 5'd0, 1'b1, "R10 2-byte flash");

    // R5 busy hold and release; R6 trigger while busy ignored
    mode = 2'b01; addr = 0; len = 0; fsize = 5'd9; trig = 1'b1;
    step();
    trig = 1'b0;
    chk(go, 1, "R5 go pulse");
    step();
    chk(go, 0, "R5 go single cycle");
    chk(busy, 1, "R5 busy held");
    addr = 32'd5000; trig = 1'b1;
    step();
    trig = 1'b0;
    chk(abort, 0, "R6 abort while busy");
    chk(err_flag, 0, "R6 err while busy");
    chk(busy, 1, "R6 busy kept");
    op_done = 1'b1;
    step();
    op_done = 1'b0;
    chk(busy, 0, "R5 busy falls after done");

    // R8 sticky flag, set beats clear
    err_ie = 1'b0; addr = 32'd5000; trig = 1'b1;
    step();
    trig = 1'b0;
    step(); step();
    chk(err_flag, 1, "R8 sticky");
    chk(irq, 0, "R9 irq disabled");
    err_ie = 1'b1;
    step();
    chk(irq, 1, "R9 irq after enable");
    err_clr = 1'b1; trig = 1'b1;
    step();
    err_clr = 1'b0; trig = 1'b0;
    chk(err_flag, 1, "R8 set wins over clear");
    err_clr = 1'b1;
    step();
    err_clr = 1'b0;
    chk(err_flag, 0, "R8 cleared");
    chk(irq, 0, "R9 irq cleared");

    // random mix around the boundary
    for (int i = 0; i < 300; i++) begin
      logic [4:0] fs;
      logic [AW-1:0] a;
      logic [LW-1:0] l;
      longint unsigned sz;
      fs = 5'($urandom_range(0, 12));
      if ($urandom_range(0, 9) == 0) fs = 5'd31;
      sz = (int'(fs) + 1 >= AW) ? (64'd1 << AW) : (64'd1 << (fs + 1));
      a = AW'($urandom_range(0, 32'(sz + sz / 4)));
      l = LW'($urandom_range(0, 32'(sz / 2)));
      run(2'($urandom_range(0, 3)), a, l, fs, 1'($urandom_range(0, 1)),
          "R2/R3/R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule